// File: doc/BRIEF.md
# UART Ring-Buffer DMA Channel

One channel that streams bytes between a UART and a circular buffer in memory. A build-time parameter fixes the direction. In transmit mode the channel fetches bytes that software has queued between the two ring pointers and hands them to the UART one at a time. In receive mode it takes bytes from the UART, stores each one in the ring and moves the write pointer forward. Each pointer is a 16-bit offset plus a wrap bit that flips on every pass around the ring, so a full ring and an empty ring are told apart without wasting a slot.

Software sets the channel up through a small register file: base address, ring length, interrupt threshold, interrupt enables and flags, the two pointers, and the controls enable, stop, flush and warm reset. The channel reports the valid and free byte counts, and raises a level interrupt when a threshold condition is flagged and enabled. Memory is reached through a one-byte request/acknowledge port, and the UART side uses valid/ready byte streams.

The mover is a four-state machine. ST_IDLE waits for work. In transmit mode it moves to ST_FETCH when the channel is enabled, not stopped and holds valid data. In receive mode it moves to ST_STORE when a byte is accepted. ST_FETCH issues a memory read and moves to ST_SEND on acknowledge. ST_SEND offers the byte and returns to ST_IDLE on the stream handshake. ST_STORE issues a memory write and returns to ST_IDLE on acknowledge. A warm reset sends any state back to ST_IDLE.

Top module: `urdma_chan`

## Requirements
- R1: After reset every register reads 0, irq is 0, tx_valid, rx_ready and mem_req are 0.
- R2: A pointer reads as offset in bits [15:0] and wrap flag in bit 16. When the hardware advances a pointer, an offset that reaches the ring length has the length subtracted and its wrap flag inverted.
- R3: VALID (0x2C) equals write offset minus read offset, plus the length when the wrap flags differ. LEFT (0x30) equals length minus VALID.
- R4: In transmit mode, bytes go out on the tx stream in ring order, each read from base plus read offset, and only while enable is 1, stop is 0 and VALID is non-zero.
- R5: In receive mode, each accepted byte is written to base plus write offset. While LEFT is 0, rx_ready stays 0 and no stored byte is overwritten.
- R6: Interrupt flags (0x14) are set in transmit mode at bit 0 while enabled with LEFT >= threshold. A write to the flag register with bit 0 = 0 clears that bit. In receive mode, bit 0 is set while enabled with VALID >= threshold and bit 1 while enabled with LEFT = 0, and writing 1s clears them. irq is the OR of flags ANDed with the enables (0x10).
- R7: Writing 1 to FLUSH (0x08) bit 0 makes it read 1 until the mover is idle (and, in transmit mode, VALID is 0), after which it clears by itself.
- R8: With STOP (0x04) at 1 the mover starts no new byte, ENABLE (0x00) drops to 0 once the current byte ends, and writes of 1 to ENABLE are ignored.
- R9: Writing 1 to bit 0 of WRST (0x0C) clears enable, stop, flush, flags and both pointers, and returns the mover to idle.
- R10: Writes to BASE (0x18), LEN (0x1C) and THRESH (0x20) are ignored while enable is 1 and accepted while it is 0.
- R11: Software writes the transmit write pointer (0x24) and the receive read pointer (0x28). Writes to the pointer that the hardware moves are ignored.
- R12: Register offsets are ENABLE 0x00, STOP 0x04, FLUSH 0x08, WRST 0x0C, IEN 0x10, IFLAG 0x14, BASE 0x18, LEN 0x1C, THRESH 0x20, WPTR 0x24, RPTR 0x28, VALID 0x2C, LEFT 0x30, STATE 0x34. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a memory write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Byte to store |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 8 | Byte returned with mem_ack |
| tx_data | output | 8 | Byte to the UART |
| tx_valid | output | 1 | tx_data is offered |
| tx_ready | input | 1 | UART accepts tx_data |
| rx_data | input | 8 | Byte from the UART |
| rx_valid | input | 1 | rx_data is offered |
| rx_ready | output | 1 | Channel accepts rx_data |

## Verification
A register write takes effect at the rising edge that samples it, and reads come back in the same cycle. A transmit byte is offered two edges after the pointer write that makes it valid. The read pointer moves on the handshake edge, and ENABLE falls one edge after a stopped mover reaches idle. A received byte reaches memory and moves the write pointer one edge after its handshake. The bench drives and samples on falling edges only. It reads counts in the cycles before the first handshake can land, and reads everything else only after a wait longer than the slowest path (three cycles per transmit byte, two per receive byte), so each check looks at a settled value.

// File: rtl/urdma_pkg.sv
package urdma_pkg;
    localparam int OFS_W  = 16;
    localparam int PTR_W  = OFS_W + 1;
    localparam int DATA_W = 32;
    localparam int REG_AW = 8;
    localparam int BYTE_W = 8;
    localparam int FLAG_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SEND  = 2'd2,
        ST_STORE = 2'd3
    } mv_state_t;

    localparam logic [REG_AW-1:0] A_ENABLE = 8'h00;
    localparam logic [REG_AW-1:0] A_STOP   = 8'h04;
    localparam logic [REG_AW-1:0] A_FLUSH  = 8'h08;
    localparam logic [REG_AW-1:0] A_WRST   = 8'h0C;
    localparam logic [REG_AW-1:0] A_IEN    = 8'h10;
    localparam logic [REG_AW-1:0] A_IFLAG  = 8'h14;
    localparam logic [REG_AW-1:0] A_BASE   = 8'h18;
    localparam logic [REG_AW-1:0] A_LEN    = 8'h1C;
    localparam logic [REG_AW-1:0] A_THR    = 8'h20;
    localparam logic [REG_AW-1:0] A_WPTR   = 8'h24;
    localparam logic [REG_AW-1:0] A_RPTR   = 8'h28;
    localparam logic [REG_AW-1:0] A_VALID  = 8'h2C;
    localparam logic [REG_AW-1:0] A_LEFT   = 8'h30;
    localparam logic [REG_AW-1:0] A_STATE  = 8'h34;

    // One-byte advance around the ring, flipping the wrap flag on a pass.
    function automatic logic [PTR_W-1:0] ring_step(input logic [PTR_W-1:0] p,
                                                   input logic [OFS_W-1:0] len);
        logic [OFS_W:0] sum;
        logic [OFS_W-1:0] ofs;
        sum = {1'b0, p[OFS_W-1:0]} + {{OFS_W{1'b0}}, 1'b1};
        if (sum >= {1'b0, len}) begin
            ofs = sum[OFS_W-1:0] - len;
            return {~p[OFS_W], ofs};
        end
        return {p[OFS_W], sum[OFS_W-1:0]};
    endfunction
endpackage

// File: rtl/urdma_ring.sv
module urdma_ring
    import urdma_pkg::*;
(
    input  logic [PTR_W-1:0] wptr,
    input  logic [PTR_W-1:0] rptr,
    input  logic [OFS_W-1:0] len,
    output logic [OFS_W-1:0] valid_cnt,
    output logic [OFS_W-1:0] left_cnt
);
    logic [OFS_W-1:0] diff;

    assign diff      = wptr[OFS_W-1:0] - rptr[OFS_W-1:0];
    assign valid_cnt = (wptr[OFS_W] ^ rptr[OFS_W]) ? (diff + len) : diff;
    assign left_cnt  = len - valid_cnt;
endmodule

// File: rtl/urdma_mover.sv
module urdma_mover
    import urdma_pkg::*;
#(
    parameter bit TX_MODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              stop,
    input  logic              abort,
    input  logic [DATA_W-1:0] base,
    input  logic [OFS_W-1:0]  hw_ofs,
    input  logic [OFS_W-1:0]  valid_cnt,
    input  logic [OFS_W-1:0]  left_cnt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic              hw_adv,
    output logic              idle,
    output logic [1:0]        state_o
);
    mv_state_t         state_q, state_d;
    logic [BYTE_W-1:0] byte_q;
    logic              go;

    assign go = en && !stop;

    // State register and byte holder
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            byte_q  <= '0;
        end else begin
            state_q <= abort ? ST_IDLE : state_d;
            if (state_q == ST_FETCH && mem_ack)
                byte_q <= mem_rdata;
            else if (state_q == ST_IDLE && rx_ready && rx_valid)
                byte_q <= rx_data;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        tx_valid = 1'b0;
        rx_ready = 1'b0;
        hw_adv   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (TX_MODE) begin
                    if (go && valid_cnt != '0) state_d = ST_FETCH;
                end else begin
                    rx_ready = go && (left_cnt != '0);
                    if (rx_ready && rx_valid) state_d = ST_STORE;
                end
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                if (mem_ack) state_d = ST_SEND;
            end
            ST_SEND: begin
                tx_valid = 1'b1;
                if (tx_ready) begin
                    hw_adv  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_STORE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    hw_adv  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign mem_addr  = base + {{(DATA_W-OFS_W){1'b0}}, hw_ofs};
    assign mem_wdata = byte_q;
    assign tx_data   = byte_q;
    assign idle      = (state_q == ST_IDLE);
    assign state_o   = state_q;

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && state_q == ST_IDLE) |=> (state_q == ST_IDLE)); // R8

    generate
        if (TX_MODE) begin : g_tx_chk
            AST_TX_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mem_req) |-> (valid_cnt != '0)); // R4
        end
    endgenerate
endmodule

// File: rtl/urdma_regs.sv
module urdma_regs
    import urdma_pkg::*;
#(
    parameter bit TX_MODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              hw_adv,
    input  logic              mv_idle,
    input  logic [1:0]        mv_state,
    input  logic [OFS_W-1:0]  valid_cnt,
    input  logic [OFS_W-1:0]  left_cnt,
    output logic              en,
    output logic              stop,
    output logic              wrst,
    output logic [DATA_W-1:0] base,
    output logic [OFS_W-1:0]  len,
    output logic [PTR_W-1:0]  wptr,
    output logic [PTR_W-1:0]  rptr,
    output logic              irq
);
    localparam logic [REG_AW-1:0] SW_PTR_A = TX_MODE ? A_WPTR : A_RPTR;

    logic              en_q, stop_q, flush_q;
    logic [DATA_W-1:0] base_q;
    logic [OFS_W-1:0]  len_q, thr_q;
    logic [FLAG_W-1:0] ien_q, flag_q, flag_set, flag_clr;
    logic [PTR_W-1:0]  sw_ptr_q, hw_ptr_q;
    logic              drained;

    function automatic logic hit(input logic [REG_AW-1:0] a);
        return reg_we && (reg_addr == a);
    endfunction

    assign wrst    = hit(A_WRST) && reg_wdata[0];
    assign drained = mv_idle && (!TX_MODE || valid_cnt == '0);

    always_comb begin
        if (TX_MODE) begin
            flag_set = {1'b0, en_q && (left_cnt >= thr_q)};
            flag_clr = {1'b0, hit(A_IFLAG) && !reg_wdata[0]};
        end else begin
            flag_set = {en_q && (left_cnt == '0) && (len_q != '0),
                        en_q && (valid_cnt >= thr_q)};
            flag_clr = hit(A_IFLAG) ? reg_wdata[FLAG_W-1:0] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            stop_q   <= 1'b0;
            flush_q  <= 1'b0;
            base_q   <= '0;
            len_q    <= '0;
            thr_q    <= '0;
            ien_q    <= '0;
            flag_q   <= '0;
            sw_ptr_q <= '0;
            hw_ptr_q <= '0;
        end else if (wrst) begin
            en_q     <= 1'b0;
            stop_q   <= 1'b0;
            flush_q  <= 1'b0;
            flag_q   <= '0;
            sw_ptr_q <= '0;
            hw_ptr_q <= '0;
        end else begin
            if (stop_q && mv_idle)              en_q <= 1'b0;
            else if (hit(A_ENABLE) && !stop_q)  en_q <= reg_wdata[0];
            if (hit(A_STOP))                    stop_q <= reg_wdata[0];
            if (hit(A_FLUSH) && reg_wdata[0])   flush_q <= 1'b1;
            else if (flush_q && drained)        flush_q <= 1'b0;
            if (!en_q && hit(A_BASE))           base_q <= reg_wdata;
            if (!en_q && hit(A_LEN))            len_q  <= reg_wdata[OFS_W-1:0];
            if (!en_q && hit(A_THR))            thr_q  <= reg_wdata[OFS_W-1:0];
            if (hit(A_IEN))
                ien_q <= TX_MODE ? {1'b0, reg_wdata[0]} : reg_wdata[FLAG_W-1:0];
            flag_q <= (flag_q & ~flag_clr) | flag_set;
            if (hit(SW_PTR_A))                  sw_ptr_q <= reg_wdata[PTR_W-1:0];
            if (hw_adv)                         hw_ptr_q <= ring_step(hw_ptr_q, len_q);
        end
    end

    assign wptr = TX_MODE ? sw_ptr_q : hw_ptr_q;
    assign rptr = TX_MODE ? hw_ptr_q : sw_ptr_q;
    assign en   = en_q;
    assign stop = stop_q;
    assign base = base_q;
    assign len  = len_q;
    assign irq  = |(flag_q & ien_q);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_ENABLE: reg_rdata[0] = en_q;
            A_STOP:   reg_rdata[0] = stop_q;
            A_FLUSH:  reg_rdata[0] = flush_q;
            A_IEN:    reg_rdata[FLAG_W-1:0] = ien_q;
            A_IFLAG:  reg_rdata[FLAG_W-1:0] = flag_q;
            A_BASE:   reg_rdata = base_q;
            A_LEN:    reg_rdata[OFS_W-1:0] = len_q;
            A_THR:    reg_rdata[OFS_W-1:0] = thr_q;
            A_WPTR:   reg_rdata[PTR_W-1:0] = wptr;
            A_RPTR:   reg_rdata[PTR_W-1:0] = rptr;
            A_VALID:  reg_rdata[OFS_W-1:0] = valid_cnt;
            A_LEFT:   reg_rdata[OFS_W-1:0] = left_cnt;
            A_STATE:  reg_rdata[1:0] = mv_state;
            default:  reg_rdata = '0;
        endcase
    end

    AST_EN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && mv_idle && en_q) |=> !en_q); // R8

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> ($stable(len_q) && $stable(base_q) && $stable(thr_q))); // R10

    generate
        if (!TX_MODE) begin : g_rx_chk
            AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
                hw_adv |-> (left_cnt != '0)); // R5
        end
    endgenerate
endmodule

// File: rtl/urdma_chan.sv
module urdma_chan
    import urdma_pkg::*;
#(
    parameter bit TX_MODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready
);
    logic              en, stop, wrst, hw_adv, mv_idle;
    logic [1:0]        mv_state;
    logic [DATA_W-1:0] base;
    logic [OFS_W-1:0]  len, valid_cnt, left_cnt, hw_ofs;
    logic [PTR_W-1:0]  wptr, rptr;

    assign hw_ofs = TX_MODE ? rptr[OFS_W-1:0] : wptr[OFS_W-1:0];

    urdma_regs #(.TX_MODE(TX_MODE)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_adv(hw_adv),
        .mv_idle(mv_idle), .mv_state(mv_state), .valid_cnt(valid_cnt),
        .left_cnt(left_cnt), .en(en), .stop(stop), .wrst(wrst), .base(base),
        .len(len), .wptr(wptr), .rptr(rptr), .irq(irq)
    );

    urdma_ring u_ring (
        .wptr(wptr), .rptr(rptr), .len(len),
        .valid_cnt(valid_cnt), .left_cnt(left_cnt)
    );

    urdma_mover #(.TX_MODE(TX_MODE)) u_mover (
        .clk(clk), .rst_n(rst_n), .en(en), .stop(stop), .abort(wrst),
        .base(base), .hw_ofs(hw_ofs), .valid_cnt(valid_cnt), .left_cnt(left_cnt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .hw_adv(hw_adv), .idle(mv_idle), .state_o(mv_state)
    );
endmodule

// File: tb/urdma_chan_bench.sv
module urdma_chan_bench;
    localparam int LEN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int nchk = 0;
    int nerr = 0;

    // transmit channel
    logic        t_we = 1'b0;
    logic [7:0]  t_addr = '0;
    logic [31:0] t_wdata = '0, t_rdata, t_maddr;
    logic        t_irq, t_mreq, t_mwe, t_tx_valid, t_rx_ready;
    logic [7:0]  t_mwdata, t_mrdata, t_tx_data;
    logic        t_tx_ready = 1'b0;
    logic [7:0]  tmem [0:511];

    // receive channel
    logic        r_we = 1'b0;
    logic [7:0]  r_addr = '0;
    logic [31:0] r_wdata = '0, r_rdata, r_maddr;
    logic        r_irq, r_mreq, r_mwe, r_tx_valid, r_rx_ready;
    logic [7:0]  r_mwdata, r_tx_data;
    logic        r_rx_valid = 1'b0;
    logic [7:0]  r_rx_data = '0;
    logic [7:0]  rmem [0:511];

    assign t_mrdata = tmem[t_maddr[8:0]];

    urdma_chan #(.TX_MODE(1'b1)) u_urdma_chan (
        .clk(clk), .rst_n(rst_n), .reg_we(t_we), .reg_addr(t_addr),
        .reg_wdata(t_wdata), .reg_rdata(t_rdata), .irq(t_irq),
        .mem_req(t_mreq), .mem_we(t_mwe), .mem_addr(t_maddr),
        .mem_wdata(t_mwdata), .mem_ack(t_mreq), .mem_rdata(t_mrdata),
        .tx_data(t_tx_data), .tx_valid(t_tx_valid), .tx_ready(t_tx_ready),
        .rx_data(8'h00), .rx_valid(1'b0), .rx_ready(t_rx_ready)
    );

    urdma_chan #(.TX_MODE(1'b0)) u_urdma_chan_rx (
        .clk(clk), .rst_n(rst_n), .reg_we(r_we), .reg_addr(r_addr),
        .reg_wdata(r_wdata), .reg_rdata(r_rdata), .irq(r_irq),
        .mem_req(r_mreq), .mem_we(r_mwe), .mem_addr(r_maddr),
        .mem_wdata(r_mwdata), .mem_ack(r_mreq), .mem_rdata(8'h00),
        .tx_data(r_tx_data), .tx_valid(r_tx_valid), .tx_ready(1'b0),
        .rx_data(r_rx_data), .rx_valid(r_rx_valid), .rx_ready(r_rx_ready)
    );

    always @(posedge clk)
        if (r_mreq && r_mwe) rmem[r_maddr[8:0]] <= r_mwdata;

    logic [7:0] txlog [0:63];
    int txn = 0;
    always @(posedge clk)
        if (t_tx_valid && t_tx_ready) begin
            txlog[txn[5:0]] <= t_tx_data;
            txn <= txn + 1;
        end

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [16:0] adv(input logic [16:0] p, input int n);
        logic [16:0] q;
        q = p;
        for (int i = 0; i < n; i++) begin
            if (int'(q[15:0]) + 1 >= LEN) q = {~q[16], 16'(int'(q[15:0]) + 1 - LEN)};
            else q = {q[16], q[15:0] + 16'd1};
        end
        return q;
    endfunction

    function automatic int occ(input logic [16:0] w, input logic [16:0] r);
        int c;
        c = int'(w[15:0]) - int'(r[15:0]);
        if (w[16] != r[16]) c = c + LEN;
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit rx, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (rx) begin r_we = 1'b1; r_addr = a; r_wdata = d; end
        else    begin t_we = 1'b1; t_addr = a; t_wdata = d; end
        @(negedge clk);
        r_we = 1'b0;
        t_we = 1'b0;
    endtask

    task automatic rd(input bit rx, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        if (rx) r_addr = a; else t_addr = a;
        #1;
        d = rx ? r_rdata : t_rdata;
    endtask

    task automatic rchk(input bit rx, input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(rx, a, v);
        check(req, v, exp);
    endtask

    logic [16:0] t_sw = '0, t_hw = '0;
    int txseen = 0;

    task automatic tx_bytes(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            check(req, {24'h0, txlog[txseen[5:0]]}, {24'h0, pat(32'h100 + int'(t_hw[15:0]))});
            t_hw = adv(t_hw, 1);
            txseen++;
        end
        check(req, txn, txseen);
    endtask

    task automatic rx_push(input logic [7:0] d);
        @(negedge clk);
        r_rx_valid = 1'b1;
        r_rx_data  = d;
        while (!r_rx_ready) @(negedge clk);
        @(negedge clk);
        r_rx_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [16:0] r_sw, r_hw;
        logic [31:0] v;
        int ks [6] = '{3, 5, 8, 1, 7, 6};
        for (int i = 0; i < 512; i++) begin tmem[i] = pat(i); rmem[i] = 8'h00; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state; R12 offsets used throughout
        foreach (ks[i]) begin end
        rchk(0, 8'h00, 0, "R1 enable");
        rchk(0, 8'h24, 0, "R1 wptr");
        rchk(0, 8'h28, 0, "R1 rptr");
        rchk(0, 8'h30, 0, "R1 left");
        rchk(0, 8'h14, 0, "R1 flags");
        rchk(1, 8'h2C, 0, "R1 rx valid");
        check("R1 ports", {27'h0, t_irq, t_tx_valid, t_mreq, r_rx_ready, r_mreq}, 0);

        // transmit configuration
        wr(0, 8'h18, 32'h100);
        wr(0, 8'h1C, LEN);
        wr(0, 8'h20, 7);
        wr(0, 8'h10, 1);
        wr(0, 8'h00, 1);
        t_tx_ready = 1'b1;
        // R10 frozen while enabled
        wr(0, 8'h1C, 5);
        wr(0, 8'h18, 32'h180);
        rchk(0, 8'h1C, LEN, "R10 len frozen");
        rchk(0, 8'h18, 32'h100, "R10 base frozen");
        // R6 left 8 >= 7
        rchk(0, 8'h14, 1, "R6 tx flag set");
        check("R6 tx irq", {31'h0, t_irq}, 1);

        // R4 / R3 / R2 sweep across several wraps
        for (int s = 0; s < 6; s++) begin
            t_sw = adv(t_sw, ks[s]);
            wr(0, 8'h24, {15'h0, t_sw});
            rchk(0, 8'h2C, ks[s], "R3 valid after write");
            rchk(0, 8'h30, LEN - ks[s], "R3 left after write");
            repeat (3 * ks[s] + 4) @(negedge clk);
            tx_bytes(ks[s], "R4 tx byte order");
            rchk(0, 8'h28, {15'h0, t_sw}, "R2 hw rptr wrap");
            rchk(0, 8'h2C, 0, "R3 drained");
        end

        // R6 clear by writing 0, then set again when space returns
        t_tx_ready = 1'b0;
        t_sw = adv(t_sw, 3);
        wr(0, 8'h24, {15'h0, t_sw});
        wr(0, 8'h14, 0);
        rchk(0, 8'h14, 0, "R6 tx flag cleared");
        check("R6 tx irq low", {31'h0, t_irq}, 0);
        t_tx_ready = 1'b1;
        repeat (20) @(negedge clk);
        rchk(0, 8'h14, 1, "R6 tx flag reset by space");
        check("R6 tx irq high", {31'h0, t_irq}, 1);
        tx_bytes(3, "R4 after stall");

        // R8 stop handshake: exactly one byte leaves
        t_sw = adv(t_sw, 4);
        wr(0, 8'h24, {15'h0, t_sw});
        wr(0, 8'h04, 1);
        repeat (10) @(negedge clk);
        rchk(0, 8'h00, 0, "R8 enable dropped");
        rchk(0, 8'h2C, 3, "R8 one byte sent");
        wr(0, 8'h00, 1);
        rchk(0, 8'h00, 0, "R8 enable ignored while stopped");
        tx_bytes(1, "R8 byte before stop");
        wr(0, 8'h04, 0);
        wr(0, 8'h00, 1);
        repeat (16) @(negedge clk);
        tx_bytes(3, "R8 resume");

        // R7 flush self-clears after the drain
        t_tx_ready = 1'b0;
        t_sw = adv(t_sw, 2);
        wr(0, 8'h24, {15'h0, t_sw});
        wr(0, 8'h08, 1);
        rchk(0, 8'h08, 1, "R7 flush pending");
        t_tx_ready = 1'b1;
        repeat (15) @(negedge clk);
        rchk(0, 8'h08, 0, "R7 flush done");
        tx_bytes(2, "R7 flushed bytes");

        // R9 warm reset mid-transfer
        t_tx_ready = 1'b0;
        t_sw = adv(t_sw, 2);
        wr(0, 8'h24, {15'h0, t_sw});
        repeat (4) @(negedge clk);
        wr(0, 8'h0C, 1);
        rchk(0, 8'h00, 0, "R9 enable");
        rchk(0, 8'h24, 0, "R9 wptr");
        rchk(0, 8'h28, 0, "R9 rptr");
        rchk(0, 8'h14, 0, "R9 flags");
        check("R9 mover idle", {31'h0, t_tx_valid}, 0);
        // R11 hw-owned pointer not writable; R10 writable when disabled
        wr(0, 8'h28, 5);
        rchk(0, 8'h28, 0, "R11 tx rptr write ignored");
        wr(0, 8'h1C, 6);
        rchk(0, 8'h1C, 6, "R10 len accepted when disabled");
        t_tx_ready = 1'b1;

        // receive channel
        wr(1, 8'h18, 32'h40);
        wr(1, 8'h1C, LEN);
        wr(1, 8'h20, 6);
        wr(1, 8'h10, 3);
        wr(1, 8'h24, 3);
        rchk(1, 8'h24, 0, "R11 rx wptr write ignored");
        wr(1, 8'h00, 1);
        r_sw = '0;
        r_hw = '0;
        for (int i = 0; i < LEN; i++) begin
            rx_push(8'hA0 + 8'(i));
            r_hw = adv(r_hw, 1);
        end
        repeat (3) @(negedge clk);
        rchk(1, 8'h2C, LEN, "R3 rx full valid");
        rchk(1, 8'h30, 0, "R3 rx full left");
        rchk(1, 8'h24, 32'h10000, "R2 rx wptr wrap");
        rchk(1, 8'h14, 3, "R6 rx flags");
        check("R6 rx irq", {31'h0, r_irq}, 1);
        for (int i = 0; i < LEN; i++)
            check("R5 rx stored", {24'h0, rmem[9'h40 + 9'(i)]}, {24'h0, 8'hA0 + 8'(i)});
        // R5 full: ready held low, nothing overwritten
        @(negedge clk);
        r_rx_valid = 1'b1;
        r_rx_data  = 8'hEE;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R5 ready low when full", {31'h0, r_rx_ready}, 0);
        end
        r_rx_valid = 1'b0;
        check("R5 no overwrite", {24'h0, rmem[9'h40]}, 32'hA0);
        r_sw = adv(r_sw, 5);
        wr(1, 8'h28, {15'h0, r_sw});
        wr(1, 8'h14, 3);
        rchk(1, 8'h14, 0, "R6 rx flags cleared");
        check("R6 rx irq low", {31'h0, r_irq}, 0);
        rx_push(8'hEE);
        r_hw = adv(r_hw, 1);
        repeat (3) @(negedge clk);
        check("R5 wrapped store", {24'h0, rmem[9'h40]}, 32'hEE);
        rchk(1, 8'h24, {15'h0, r_hw}, "R2 rx wptr after wrap");
        rchk(1, 8'h2C, occ(r_hw, r_sw), "R3 rx valid after wrap");
        // receive sweep over further wraps
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 3; i++) begin
                check("R5 store addr free", {31'h0, (occ(r_hw, r_sw) < LEN)}, 1);
                rx_push(8'(16 * s + i));
                repeat (3) @(negedge clk);
                check("R5 rx byte", {24'h0, rmem[9'h40 + 9'(r_hw[15:0])]}, {24'h0, 8'(16 * s + i)});
                r_hw = adv(r_hw, 1);
            end
            rchk(1, 8'h24, {15'h0, r_hw}, "R2 rx wptr sweep");
            rchk(1, 8'h2C, occ(r_hw, r_sw), "R3 rx valid sweep");
            r_sw = adv(r_sw, 3);
            wr(1, 8'h28, {15'h0, r_sw});
            rchk(1, 8'h30, LEN - occ(r_hw, r_sw), "R3 rx left sweep");
        end
        // R7 receive flush clears once idle
        wr(1, 8'h08, 1);
        repeat (2) @(negedge clk);
        rchk(1, 8'h08, 0, "R7 rx flush");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule